// File: doc/BRIEF.md
# Interrupt Line Source Status

This block sits between a large set of peripheral interrupt request wires and the 32 request inputs of a CPU interrupt controller. Every source is wired to one CPU line and to one bit position inside that line's status word. Each line drives its request output whenever any bit in its status word is set. Software can read any line's status word through a small read port. An interrupt handler therefore learns which sources caused its line to fire with a single read, and does not have to poll each peripheral in turn.

Lines come in three kinds, chosen at elaboration time by parameters. A direct line collects raw sources. A nested line collects the requests of two direct lines, so a shared handler reads the nested line first to see which sub-line is pending, then reads that sub-line to find the source. The remaining lines have no sources; they read as zero and never request. Status bits are live. They follow the source levels without latching, and no access path can change them.

Top module: `irq_line_status`

## Requirements
- R1: Source s (0 <= s < NUM_SRC) appears in direct line s mod DIRECT_LINES at bit position s div DIRECT_LINES. Lines 0 to DIRECT_LINES-1 are direct lines. With the defaults (40 sources, 24 direct lines), lines 0..15 hold two sources and lines 16..23 hold one.
- R2: line_irq[l] is high in the same cycle as a source change exactly when line l's status word is nonzero.
- R3: A read (acc_en=1, acc_wr=0, acc_line=l) at a rising edge loads rd_data with line l's status word as it stands at that edge. Without an access, rd_data holds its value.
- R4: A write access (acc_en=1, acc_wr=1) leaves rd_data unchanged, and the status words and line_irq still follow the sources.
- R5: Bit positions in a direct line that have no source mapped to them read as 0.
- R6: Nested line DIRECT_LINES+k (0 <= k < NEST_PAIRS) shows the request of direct line 2k at bit 0 and the request of direct line 2k+1 at bit 1. All its other bits read 0.
- R7: Lines at or above DIRECT_LINES+NEST_PAIRS (28..31 by default) read as all zero and keep line_irq low.
- R8: A two-step lookup works. A read of the nested line names the pending sub-line, and a read of that sub-line names the pending source.
- R9: After synchronous reset, rd_data is zero.
- R10: Status bits are not sticky. Once a source drops, the next read of its line shows the bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Raw peripheral request levels |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | Access is a write (ignored for data) |
| acc_line | input | 5 | Line index to read |
| rd_data | output | 32 | Registered status word of the last line read |
| line_irq | output | 32 | Per-line request to the CPU interrupt controller |

## Verification
The bench sweeps every single source. This would expose a swapped line/bit formula or a source landing in the wrong word. It follows each sweep with a nested-line read and then a sub-line read, which would catch a parent that ignores one child or takes its bits from the wrong pair. A write access placed between a read and the next check would reveal a design that loads rd_data on writes. Reading a line after its source has dropped would catch sticky status bits. Reads of the empty lines and of the high bits of direct lines would reveal stray ones, and random dense and sparse patterns check line_irq against the expected OR of each word.

// File: rtl/irq_line_status_pkg.sv
package irq_line_status_pkg;

    localparam int NUM_LINES = 32;
    localparam int DATA_W    = 32;
    localparam int LINE_AW   = $clog2(NUM_LINES);

    typedef logic [DATA_W-1:0]  line_word_t;
    typedef logic [LINE_AW-1:0] line_idx_t;

    typedef enum logic [1:0] {
        LK_DIRECT = 2'd0,
        LK_NESTED = 2'd1,
        LK_EMPTY  = 2'd2
    } line_kind_e;

    typedef struct packed {
        logic      fire;
        logic      wr;
        line_idx_t line;
    } acc_req_t;

    function automatic line_kind_e kind_of(int line, int ndirect, int npairs);
        if (line < ndirect)
            return LK_DIRECT;
        else if (line < ndirect + npairs)
            return LK_NESTED;
        return LK_EMPTY;
    endfunction

    // Source index feeding (line, bit) of a direct line, or -1 if none.
    function automatic int src_of(int line, int bit_pos, int nsrc, int ndirect);
        int s;
        if (kind_of(line, ndirect, 0) != LK_DIRECT)
            return -1;
        s = bit_pos * ndirect + line;
        if (s < nsrc)
            return s;
        return -1;
    endfunction

    // Child line feeding (line, bit) of a nested line, or -1 if none.
    function automatic int child_of(int line, int bit_pos, int ndirect, int npairs);
        if (kind_of(line, ndirect, npairs) != LK_NESTED || bit_pos > 1)
            return -1;
        return 2 * (line - ndirect) + bit_pos;
    endfunction

    function automatic int bits_per_direct(int nsrc, int ndirect);
        return (nsrc + ndirect - 1) / ndirect;
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_line_status_pkg::*;
#(
    parameter int NUM_SRC      = 40,
    parameter int DIRECT_LINES = 24
) (
    input  logic [NUM_SRC-1:0] src_req,
    output line_word_t         direct_word [DIRECT_LINES]
);

    for (genvar l = 0; l < DIRECT_LINES; l++) begin : g_line
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam int S = src_of(l, b, NUM_SRC, DIRECT_LINES);
            if (S >= 0) begin : g_src
                assign direct_word[l][b] = src_req[S];
            end else begin : g_none
                assign direct_word[l][b] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_nest_map.sv
module irq_nest_map
    import irq_line_status_pkg::*;
#(
    parameter int DIRECT_LINES = 24,
    parameter int NEST_PAIRS   = 4
) (
    input  line_word_t direct_word [DIRECT_LINES],
    output line_word_t line_word   [NUM_LINES]
);

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam int C = child_of(l, b, DIRECT_LINES, NEST_PAIRS);
            if (l < DIRECT_LINES) begin : g_direct
                assign line_word[l][b] = direct_word[l][b];
            end else if (C >= 0) begin : g_nested
                assign line_word[l][b] = |direct_word[C];
            end else begin : g_empty
                assign line_word[l][b] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
    import irq_line_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_req_t   req,
    input  line_word_t line_word [NUM_LINES],
    output line_word_t rd_data
);

    logic rd_fire;
    assign rd_fire = req.fire && !req.wr;

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_fire)
            rd_data <= line_word[req.line];
    end

    // Writes and idle cycles leave the read register alone.
    p_hold_on_write_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> $stable(rd_data));

endmodule

// File: rtl/irq_line_status.sv
module irq_line_status
    import irq_line_status_pkg::*;
#(
    parameter int NUM_SRC      = 40,
    parameter int DIRECT_LINES = 24,
    parameter int NEST_PAIRS   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic                acc_en,
    input  logic                acc_wr,
    input  logic [LINE_AW-1:0]  acc_line,
    output logic [DATA_W-1:0]   rd_data,
    output logic [NUM_LINES-1:0] line_irq
);

    localparam int MAX_BITS   = bits_per_direct(NUM_SRC, DIRECT_LINES);
    localparam int FIRST_EMPT = DIRECT_LINES + NEST_PAIRS;

    line_word_t direct_word [DIRECT_LINES];
    line_word_t line_word   [NUM_LINES];
    acc_req_t   req;

    irq_src_map #(
        .NUM_SRC      (NUM_SRC),
        .DIRECT_LINES (DIRECT_LINES)
    ) u_src_map (
        .src_req     (src_req),
        .direct_word (direct_word)
    );

    irq_nest_map #(
        .DIRECT_LINES (DIRECT_LINES),
        .NEST_PAIRS   (NEST_PAIRS)
    ) u_nest_map (
        .direct_word (direct_word),
        .line_word   (line_word)
    );

    assign req = '{fire: acc_en, wr: acc_wr, line: acc_line};

    irq_rd_port u_rd_port (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .line_word (line_word),
        .rd_data   (rd_data)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_irq
        assign line_irq[l] = |line_word[l];
    end

    // A nonzero read word must match the request the line showed at read time.
    p_rd_vs_irq_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr) |=> ((rd_data != '0) == $past(line_irq[acc_line])));

    // Empty lines read as zero.
    p_empty_line_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && int'(acc_line) >= FIRST_EMPT) |=> (rd_data == '0));

    // Direct lines have nothing above their mapped bits.
    p_unused_bits_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !acc_wr && int'(acc_line) < DIRECT_LINES) |=> ((rd_data >> MAX_BITS) == '0));

    // A nested line requests exactly when one of its two children does.
    for (genvar k = 0; k < NEST_PAIRS; k++) begin : g_nest_chk
        p_nest_follow_r6: assert property (@(posedge clk) disable iff (rst)
            line_irq[DIRECT_LINES+k] == (line_irq[2*k] | line_irq[2*k+1]));
    end

endmodule

// File: tb/irq_line_status_bench.sv
`timescale 1ns/1ps
module irq_line_status_bench;

    localparam int NSRC  = 40;
    localparam int NDIR  = 24;
    localparam int NPAIR = 4;
    localparam int NL    = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_req = '0;
    logic            acc_en = 1'b0;
    logic            acc_wr = 1'b0;
    logic [4:0]      acc_line = '0;
    logic [31:0]     rd_data;
    logic [NL-1:0]   line_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_line_status u_irq_line_status (
        .clk      (clk),
        .rst      (rst),
        .src_req  (src_req),
        .acc_en   (acc_en),
        .acc_wr   (acc_wr),
        .acc_line (acc_line),
        .rd_data  (rd_data),
        .line_irq (line_irq)
    );

    function automatic logic [31:0] exp_direct(int line, logic [NSRC-1:0] s);
        logic [31:0] w = '0;
        for (int b = 0; b < 32; b++)
            if (b * NDIR + line < NSRC) w[b] = s[b * NDIR + line];
        return w;
    endfunction

    function automatic logic [31:0] exp_word(int line, logic [NSRC-1:0] s);
        logic [31:0] w = '0;
        if (line < NDIR) begin
            w = exp_direct(line, s);
        end else if (line < NDIR + NPAIR) begin
            w[0] = |exp_direct(2 * (line - NDIR), s);
            w[1] = |exp_direct(2 * (line - NDIR) + 1, s);
        end
        return w;
    endfunction

    function automatic logic [NL-1:0] exp_irq(logic [NSRC-1:0] s);
        logic [NL-1:0] v;
        for (int l = 0; l < NL; l++) v[l] = |exp_word(l, s);
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive sources and read a line; check irq same cycle, rd_data after the edge.
    task automatic do_read(string req, int line, logic [NSRC-1:0] s);
        @(negedge clk);
        src_req  = s;
        acc_en   = 1'b1;
        acc_wr   = 1'b0;
        acc_line = line[4:0];
        #1;
        check("R2 line_irq", line_irq, exp_irq(s));
        @(negedge clk);
        acc_en = 1'b0;
        check(req, rd_data, exp_word(line, s));
    endtask

    initial begin
        logic [NSRC-1:0] s;
        logic [31:0]     held;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check("R9 reset rd_data", rd_data, 32'h0);
        check("R9 reset line_irq", line_irq, 32'h0);
        rst = 1'b0;

        // R1 R5: single-source sweep over every source
        for (int i = 0; i < NSRC; i++) begin
            s = '0;
            s[i] = 1'b1;
            do_read("R1 single source", i % NDIR, s);
            check("R5 upper bits", rd_data >> 2, 32'h0);
        end

        // R6 R8: nested line then sub-line
        s = '0; s[25] = 1'b1;                 // line 1, bit 1
        do_read("R8 nested names sub-line", 24, s);
        check("R6 nested bit1", rd_data, 32'h2);
        do_read("R8 sub-line names source", 1, s);
        check("R8 sub-line bit", rd_data, 32'h2);
        s = '0; s[6] = 1'b1; s[7] = 1'b1;     // lines 6 and 7 -> nested line 27
        do_read("R6 nested both children", 27, s);
        check("R6 nested value", rd_data, 32'h3);

        // R7: empty lines
        s = '1;
        for (int l = NDIR + NPAIR; l < NL; l++)
            do_read("R7 empty line", l, s);
        check("R7 empty irq low", {28'h0, line_irq[31:28]}, 32'h0);

        // R10: bit clears after source drops
        s = '0; s[5] = 1'b1;
        do_read("R10 source high", 5, s);
        do_read("R10 source dropped", 5, '0);

        // R4 R3: write access and idle cycle do not load rd_data
        s = '0; s[3] = 1'b1; s[27] = 1'b1;
        do_read("R3 read before write", 3, s);
        held = rd_data;
        @(negedge clk);
        src_req  = '0;
        acc_en   = 1'b1;
        acc_wr   = 1'b1;
        acc_line = 5'd3;
        #1;
        check("R4 irq follows sources during write", line_irq, exp_irq('0));
        @(negedge clk);
        acc_en = 1'b0;
        acc_wr = 1'b0;
        check("R4 write leaves rd_data", rd_data, held);
        @(negedge clk);
        check("R3 idle holds rd_data", rd_data, held);

        // Random dense and sparse patterns
        for (int n = 0; n < 400; n++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            if (n % 2 == 1) r = r & {$urandom, $urandom} & {$urandom, $urandom};
            do_read("R3 random read", $urandom % NL, r[NSRC-1:0]);
        end

        // R9: reset again after activity
        @(negedge clk);
        rst = 1'b1;
        src_req = '0;
        @(negedge clk);
        check("R9 reset after use", rd_data, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule